// File: doc/BRIEF.md
# Frame-Rate Tick Generator

This block turns the peripheral clock into one strobe per serial character frame. The transmit and receive FIFOs of a serial port step on this strobe and each moves one byte per frame. The block does not produce a baud tick for each bit. The spacing between strobes is a fixed frame factor, times a prescale chosen by a two-bit clock-select field, times one more than an eight-bit rate value.

The block holds two writable registers. The line-mode register keeps the character length, the parity and stop-bit settings and the clock select. The rate register holds the divider value. A write that can change the frame period restarts the count, so the next strobe arrives one full new period after the write. While an external clock source is selected, the block produces no strobes and holds its count at zero.

Top module: `frame_tick_gen`

## Requirements
- R1: While rst_ni is low, tick_o, mode_o and rate_o are all 0. After reset is released, the first strobe comes FRAME_MULT clock edges later, which is the period for clock select 0 and rate 0.
- R2: Clock-select values 0, 1, 2 and 3 in mode bits [1:0] give a prescale of 1, 4, 16 and 64 peripheral clocks.
- R3: Consecutive strobes are FRAME_MULT × prescale × (rate + 1) clock edges apart. FRAME_MULT defaults to 32.
- R4: Each strobe is high for exactly one clock cycle.
- R5: Every write to the rate register restarts the count, including a write of the value already held. The first strobe after the write comes one full new period after the edge that takes the write.
- R6: A mode write that changes bits [1:0] restarts the count in the same way as R5.
- R7: A mode write that leaves bits [1:0] unchanged does not move the strobe timing.
- R8: The mode register keeps only these bits: [5] 7-bit characters, [4] parity enable, [3] odd parity, [2] two stop bits, [1:0] clock select. Bits [7:6] always read 0.
- R9: While ext_clk_en_i is high, no strobe is produced. The first strobe comes one period after the last clock edge that saw ext_clk_en_i high.
- R10: rate_o reads back the last value written to the rate register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_clk_en_i | input | 1 | External clock source selected; internal strobes stop |
| mode_we_i | input | 1 | Write strobe for the line-mode register |
| mode_wdata_i | input | 8 | Line-mode write data |
| rate_we_i | input | 1 | Write strobe for the rate register |
| rate_wdata_i | input | RATE_W | Rate write data |
| mode_o | output | 8 | Line-mode register readback |
| rate_o | output | RATE_W | Rate register readback |
| tick_o | output | 1 | One-cycle frame strobe |

## Verification
The bench builds the block with FRAME_MULT set to 2 and keeps RATE_W at its default of 8. This brings the longest period (clock select 3, rate 255) down to 32768 cycles, so that corner can be measured edge for edge within the run. The smallest period of 2 cycles makes back-to-back strobes separated by one idle cycle, which tests the single-cycle pulse. Each of the four prescale values is also exercised. Restart timing is tested with writes issued partway through a period, so a strobe that stays on the old schedule is seen as an unexpected strobe.

// File: rtl/frame_tick_pkg.sv
package frame_tick_pkg;

  localparam int SEL_W = 2;
  localparam int SEL_N = 1 << SEL_W;

  typedef struct packed {
    logic [1:0]       rsvd;
    logic             len7;
    logic             par_en;
    logic             par_odd;
    logic             stop2;
    logic [SEL_W-1:0] clk_sel;
  } mode_t;

  localparam logic [7:0] MODE_KEEP_MASK = 8'h3F;

endpackage

// File: rtl/frame_mode_regs.sv
module frame_mode_regs
  import frame_tick_pkg::*;
#(
  parameter int RATE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_we_i,
  input  logic [7:0]        mode_wdata_i,
  input  logic              rate_we_i,
  input  logic [RATE_W-1:0] rate_wdata_i,
  output mode_t             mode_o,
  output logic [RATE_W-1:0] rate_o,
  output logic              restart_o
);

  mode_t             mode_q;
  logic [RATE_W-1:0] rate_q;
  logic              sel_change;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      rate_q <= '0;
    end else begin
      if (mode_we_i) mode_q <= mode_t'(mode_wdata_i & MODE_KEEP_MASK);
      if (rate_we_i) rate_q <= rate_wdata_i;
    end
  end

  // only a clock-select change alters the period
  assign sel_change = mode_we_i && (mode_wdata_i[SEL_W-1:0] != mode_q.clk_sel);
  assign restart_o  = rate_we_i | sel_change;
  assign mode_o     = mode_q;
  assign rate_o     = rate_q;

  // R8
  mode_rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_i |=> (mode_q.rsvd == 2'b00));

endmodule

// File: rtl/frame_period_calc.sv
module frame_period_calc
  import frame_tick_pkg::*;
#(
  parameter int FRAME_MULT = 32,
  parameter int RATE_W     = 8,
  parameter int PS_STEP    = 2,
  parameter int CNT_W      = 20
) (
  input  logic [SEL_W-1:0]  clk_sel_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic [CNT_W-1:0]  period_o
);

  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] opt [SEL_N];

  assign base = CNT_W'(FRAME_MULT) * (CNT_W'(rate_i) + CNT_W'(1));

  // prescale = 2^(PS_STEP*sel): 1, 4, 16, 64 by default
  for (genvar g = 0; g < SEL_N; g++) begin : g_ps
    assign opt[g] = base << (PS_STEP * g);
  end

  assign period_o = opt[clk_sel_i];

endmodule

// File: rtl/frame_counter.sv
module frame_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  input  logic             restart_i,
  input  logic             hold_i,
  output logic             tick_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             tick_q;
  logic             wrap;

  assign wrap = (cnt_q == period_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (restart_i || hold_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;

  // R4
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_q && period_i > CNT_W'(1)) |=> !tick_q);

  // R9
  ext_hold_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> !tick_q);

  // R5
  restart_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (!tick_q && cnt_q == '0));

  // R3
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < period_i);

endmodule

// File: rtl/frame_tick_gen.sv
module frame_tick_gen
  import frame_tick_pkg::*;
#(
  parameter int FRAME_MULT = 32,
  parameter int RATE_W     = 8,
  parameter int PS_STEP    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_clk_en_i,
  input  logic              mode_we_i,
  input  logic [7:0]        mode_wdata_i,
  input  logic              rate_we_i,
  input  logic [RATE_W-1:0] rate_wdata_i,
  output logic [7:0]        mode_o,
  output logic [RATE_W-1:0] rate_o,
  output logic              tick_o
);

  localparam int CNT_W = $clog2(FRAME_MULT) + PS_STEP * (SEL_N - 1) + RATE_W + 1;

  mode_t             mode_w;
  logic [RATE_W-1:0] rate_w;
  logic              restart_w;
  logic [CNT_W-1:0]  period_w;

  frame_mode_regs #(.RATE_W(RATE_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_we_i    (mode_we_i),
    .mode_wdata_i (mode_wdata_i),
    .rate_we_i    (rate_we_i),
    .rate_wdata_i (rate_wdata_i),
    .mode_o       (mode_w),
    .rate_o       (rate_w),
    .restart_o    (restart_w)
  );

  frame_period_calc #(
    .FRAME_MULT (FRAME_MULT),
    .RATE_W     (RATE_W),
    .PS_STEP    (PS_STEP),
    .CNT_W      (CNT_W)
  ) u_calc (
    .clk_sel_i (mode_w.clk_sel),
    .rate_i    (rate_w),
    .period_o  (period_w)
  );

  frame_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .period_i  (period_w),
    .restart_i (restart_w),
    .hold_i    (ext_clk_en_i),
    .tick_o    (tick_o)
  );

  assign mode_o = mode_w;
  assign rate_o = rate_w;

  // R7
  period_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_we_i && !rate_we_i) |=> $stable(period_w));

endmodule

// File: tb/tb_frame_tick_gen.sv
`timescale 1ns/1ps
module tb_frame_tick_gen;

  localparam int FM = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_en = 1'b0;
  logic       mode_we = 1'b0;
  logic [7:0] mode_wd = '0;
  logic       rate_we = 1'b0;
  logic [7:0] rate_wd = '0;
  logic [7:0] mode_rd;
  logic [7:0] rate_rd;
  logic       tick;

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  frame_tick_gen #(.FRAME_MULT(FM), .RATE_W(8), .PS_STEP(2)) dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .ext_clk_en_i (ext_en),
    .mode_we_i    (mode_we),
    .mode_wdata_i (mode_wd),
    .rate_we_i    (rate_we),
    .rate_wdata_i (rate_wd),
    .mode_o       (mode_rd),
    .rate_o       (rate_rd),
    .tick_o       (tick)
  );

  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int per(input int sel, input int rate);
    return FM * (1 << (2 * sel)) * (rate + 1);
  endfunction

  task automatic push(input int anchor, input int p, input int n, input string tag);
    for (int i = 1; i <= n; i++) begin
      exp_q.push_back(anchor + i * p);
      tag_q.push_back(tag);
    end
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  task automatic wr_rate(input int v, output int anchor);
    rate_wd = v[7:0];
    rate_we = 1'b1;
    anchor  = cyc + 1;
    @(negedge clk);
    rate_we = 1'b0;
  endtask

  task automatic wr_mode(input int v, output int anchor);
    mode_wd = v[7:0];
    mode_we = 1'b1;
    anchor  = cyc + 1;
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  // scoreboard monitor: strobe edges against expected queue
  always @(negedge clk) begin
    if (rst_n && !done) begin
      while (exp_q.size() > 0 && exp_q[0] < cyc) begin
        chk(1'b0, {tag_q[0], " missed strobe"}, cyc, exp_q[0]);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
      if (tick) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected strobe", cyc, -1);
        end else begin
          chk(exp_q[0] == cyc, tag_q[0], cyc, exp_q[0]);
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int a;
    int a2;
    int h;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(tick == 1'b0, "R1 tick in reset", tick, 0);
    chk(mode_rd == 8'h00, "R1 mode in reset", mode_rd, 0);
    chk(rate_rd == 8'h00, "R1 rate in reset", rate_rd, 0);
    push(0, per(0, 0), 3, "R1");
    rst_n = 1'b1;
    drain();

    // R3 rate 5, prescale 1
    wr_rate(5, a);
    push(a, per(0, 5), 3, "R3");
    chk(rate_rd == 8'd5, "R10 rate readback", rate_rd, 5);
    drain();

    // R6 clock select change to 1
    wr_mode(8'h01, a);
    push(a, per(1, 5), 3, "R6");
    chk(mode_rd == 8'h01, "R8 mode readback", mode_rd, 1);
    drain();

    // R2 select 2, written mid-period
    repeat (5) @(negedge clk);
    wr_mode(8'h02, a);
    push(a, per(2, 5), 2, "R2");
    drain();

    // R6 select 3, then R7 same-select write mid-period
    wr_mode(8'h03, a);
    push(a, per(3, 5), 1, "R6");
    push(a + per(3, 5), per(3, 5), 2, "R7");
    wait_until(a + 300);
    wr_mode(8'hFF, a2);
    chk(mode_rd == 8'h3F, "R8 reserved bits masked", mode_rd, 8'h3F);
    drain();

    // R5 same rate value rewritten mid-period restarts
    repeat (100) @(negedge clk);
    wr_rate(5, a);
    push(a, per(3, 5), 2, "R5");
    drain();

    // R2 back to select 0 with rate 3
    wr_rate(3, a);
    wr_mode(8'h00, a);
    push(a, per(0, 3), 2, "R2");
    wait_until(a + per(0, 3) + 1);
    chk(tick == 1'b0, "R4 strobe one cycle wide", tick, 0);
    drain();

    // R9 external clock selected: no strobes
    ext_en = 1'b1;
    repeat (50) @(negedge clk);
    chk(tick == 1'b0, "R9 tick while external", tick, 0);
    h = cyc;
    ext_en = 1'b0;
    push(h, per(0, 3), 2, "R9");
    drain();

    // R3 longest period
    wr_rate(255, a);
    wr_mode(8'h03, a);
    push(a, per(3, 255), 2, "R3");
    chk(rate_rd == 8'd255, "R10 rate readback max", rate_rd, 255);
    drain();

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R3 pending strobes", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule